// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an 8-bit general-purpose I/O port. A small synchronous register bus holds four byte-wide control registers: an output-data latch, a pull-up request mask, a slew-control request mask and a direction mask. For every pin the block drives four pad-cell controls: an output value, an output enable, an effective pull-up enable and an effective slew-control enable. It also takes in the pad's input level through a two-flop synchronizer.

Direction decides, one bit at a time, how the other registers act. A pull-up request takes effect only on input pins. A slew request takes effect only on output pins. A read of the data register returns the synchronized pin level on input bits and the latched value on output bits. A write to the data register always updates all eight latch bits. Turning a pin from input to output therefore drives the value that was latched earlier, with no further write.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, all four registers read 0x00, and pad_oe, pad_pu and pad_slew are all 0. Every pin is then a high-impedance input with no pull-up.
- R2: Direction bit n = 1 makes pin n an output (pad_oe[n] = 1). Direction bit n = 0 makes it an input (pad_oe[n] = 0).
- R3: A write to address 0 (data) stores all eight bits, whatever the direction. pad_out presents the latched value, and only pins with pad_oe = 1 drive it.
- R4: A read of address 0 returns, on each input bit, the synchronized pad level. On each output bit it returns the latched data bit.
- R5: The pad level reaches data reads through two register stages. A pad change first shows in a read after the second rising clock edge.
- R6: pad_pu[n] is 1 only when pull-up request bit n (address 1) is 1 and pin n is an input. Output pins always have pad_pu = 0.
- R7: pad_slew[n] is 1 only when slew request bit n (address 2) is 1 and pin n is an output. Input pins always have pad_slew = 0.
- R8: Addresses 1 (pull-up), 2 (slew) and 3 (direction) read back exactly the value last written.
- R9: When a pin changes from input to output, it drives the data bit latched while it was an input, with no new write.
- R10: Register writes happen only on a rising clock edge with bus_wr = 1. While bus_wr = 0, bus_wdata has no effect on any register. bus_rdata is combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 pull-up, 2 slew, 3 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Latched output value toward the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Effective pull-up enable per pin |
| pad_slew | output | 8 | Effective slew-control enable per pin |

## Verification
The following are checked on every cycle:
- Pull-up and output enable are never both active on the same pin.
- Slew control never appears on an input pin.
- A strobed write lands in the addressed register on the next edge.
- With no strobe, no register changes.
- The synchronizer output equals the pad level from two edges earlier.

Only the bench scenarios can show the following:
- The per-bit mix of pin level and latched value in data reads.
- The exact read latency of a pad change.
- Latched data appearing when a pin turns into an output.
- The reset values seen through the bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W   = 8;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

    typedef logic [PORT_W-1:0] port_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_PULL = 2'd1,
        SEL_SLEW = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        port_t latch;
        port_t pull_req;
        port_t slew_req;
        port_t dir;
    } ctrl_regs_t;

    typedef struct packed {
        port_t value;
        port_t oe;
        port_t pu;
        port_t slew;
    } pad_ctrl_t;

    localparam ctrl_regs_t CTRL_RESET = '{default: '0};

    // Per bit: the latched value where the pin drives, the sampled pin level elsewhere
    function automatic port_t data_view(port_t dir, port_t latch, port_t level);
        return (dir & latch) | (~dir & level);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R5: the sampled level lags the pad by exactly two edges
            p_sync_latency_r5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (d_sync == $past(d_async, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic              wr_en,
    input  port_t             wr_data,
    output ctrl_regs_t        regs
);
    ctrl_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= CTRL_RESET;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_DATA: regs_q.latch    <= wr_data;
                SEL_PULL: regs_q.pull_req <= wr_data;
                SEL_SLEW: regs_q.slew_req <= wr_data;
                SEL_DIR:  regs_q.dir      <= wr_data;
                default:  regs_q          <= regs_q;
            endcase
        end
    end

    assign regs = regs_q;

    // R3: a data write stores all bits regardless of direction
    p_data_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DATA) |=> (regs_q.latch == $past(wr_data)));
    // R8: a direction write stores exactly the written value
    p_dir_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DIR) |=> (regs_q.dir == $past(wr_data)));
    // R10: no strobe, no register change
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_regs_t regs,
    output pad_ctrl_t  pads
);
    genvar n;
    generate
        for (n = 0; n < PORT_W; n++) begin : g_pin
            always_comb begin
                pads.value[n] = regs.latch[n];
                pads.oe[n]    = regs.dir[n];
                pads.pu[n]    = regs.pull_req[n] & ~regs.dir[n];
                pads.slew[n]  = regs.slew_req[n] &  regs.dir[n];
            end
        end
    endgenerate

    // R6: pull-up never on a driving pin
    p_pu_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (pads.pu & pads.oe) == '0);
    // R7: slew control never on an input pin
    p_slew_excl_r7: assert property (@(posedge clk) disable iff (rst)
        (pads.slew & ~pads.oe) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    output logic [PORT_W-1:0] pad_slew
);
    ctrl_regs_t regs;
    pad_ctrl_t  pads;
    port_t      level_sync;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .d_sync  (level_sync)
    );

    gpio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (bus_addr),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .regs    (regs)
    );

    gpio_padctl u_padctl (
        .clk  (clk),
        .rst  (rst),
        .regs (regs),
        .pads (pads)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = data_view(regs.dir, regs.latch, level_sync);
            SEL_PULL: bus_rdata = regs.pull_req;
            SEL_SLEW: bus_rdata = regs.slew_req;
            SEL_DIR:  bus_rdata = regs.dir;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out  = pads.value;
    assign pad_oe   = pads.oe;
    assign pad_pu   = pads.pu;
    assign pad_slew = pads.slew;

    // R2: output enable follows the direction register as read over the bus
    p_oe_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SEL_DIR) |-> (bus_rdata == pad_oe));
    // R4: on output bits a data read returns the driven latch value
    p_rd_out_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SEL_DATA) |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_slew;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_slew(pad_slew)
    );

    typedef enum int {K_RD, K_OE, K_OUT, K_PU, K_SLEW} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    // Driver side
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string r);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = K_RD; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic exp_pin(input kind_e k, input logic [7:0] e, input string r);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    // Monitor side: sample 2 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_OE:    act = pad_oe;
                    K_OUT:   act = pad_out;
                    K_PU:    act = pad_pu;
                    default: act = pad_slew;
                endcase
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        exp_rd(0, 8'h00, "R1 data");
        exp_rd(1, 8'h00, "R1 pull");
        exp_rd(2, 8'h00, "R1 slew");
        exp_rd(3, 8'h00, "R1 dir");
        exp_pin(K_OE, 8'h00, "R1 oe");
        exp_pin(K_PU, 8'h00, "R1 pu");
        exp_pin(K_SLEW, 8'h00, "R1 slew pin");
        // R2 direction
        wr(3, 8'h0F);
        exp_pin(K_OE, 8'h0F, "R2 oe");
        // R3 data write latches all bits
        wr(0, 8'hA5);
        exp_pin(K_OUT, 8'hA5, "R3 out");
        exp_pin(K_OE, 8'h0F, "R3 oe");
        // R4 mixed read: low nibble latch 5, high nibble pin level 3
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        exp_rd(0, 8'h35, "R4 mixed read");
        // R5 two-stage latency: change pad just before an edge
        @(negedge clk);
        pad_in = 8'hFF;
        @(negedge clk);                     // one edge passed
        #1;
        tests++;
        if (bus_rdata !== 8'h35) begin
            fails++;
            $display("FAIL R5 after one edge actual=%02h expected=35", bus_rdata);
        end
        exp_rd(0, 8'hF5, "R5 after two edges");
        // R6 pull-up gating
        wr(1, 8'hFF);
        exp_pin(K_PU, 8'hF0, "R6 pu");
        // R7 slew gating
        wr(2, 8'hFF);
        exp_pin(K_SLEW, 8'h0F, "R7 slew");
        // R8 exact readback
        wr(1, 8'h5A);
        exp_rd(1, 8'h5A, "R8 pull readback");
        exp_rd(2, 8'hFF, "R8 slew readback");
        exp_rd(3, 8'h0F, "R8 dir readback");
        exp_pin(K_PU, 8'h50, "R6 pu pattern");
        // R10 no strobe, no change
        @(negedge clk);
        bus_addr = 3; bus_wdata = 8'hC3; bus_wr = 0;
        repeat (2) @(negedge clk);
        exp_rd(3, 8'h0F, "R10 dir unchanged");
        exp_rd(0, 8'hF5, "R10 data unchanged");
        // R9 input to output drives earlier latched bits
        pad_in = 8'h00;
        wr(3, 8'hFF);
        exp_pin(K_OE, 8'hFF, "R9 oe");
        exp_pin(K_OUT, 8'hA5, "R9 out");
        exp_rd(0, 8'hA5, "R9 read latch");
        exp_pin(K_PU, 8'h00, "R9 pu off");
        exp_pin(K_SLEW, 8'hFF, "R9 slew on");
        // back to all inputs: reads follow pin level
        wr(3, 8'h00);
        repeat (3) @(negedge clk);
        exp_rd(0, 8'h00, "R4 all inputs");
        exp_pin(K_SLEW, 8'h00, "R7 slew off");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule